// File: doc/BRIEF.md
# Crossing Tick and Sub-Tick Counter

This block keeps the timing reference for a data path running at eight clocks per beam crossing. An 11-bit synchronous counter advances on every clock. Its three low bits give the sub-tick (0 to 7) within a crossing. Its eight high bits give the crossing tick (1 to 159). The counter rolls over from the last sub-tick of tick 159 to sub-tick 0 of tick 1. A 2-bit turn counter advances at each rollover, so that monitoring memories can address several turns.

The counter is not cleared to zero. It is phase-aligned by a begin-of-turn marker. At a clock edge that starts a crossing, a one-cycle first-edge enable is high. If the begin-of-turn marker is also high at that edge, the counter loads a programmable 11-bit preset. The preset is chosen during commissioning so that it absorbs the latency of the whole system. A simple write port sets the preset.

The live-crossing marker is sampled at the same crossing edges. The sampled value is held as a registered flag for the whole crossing, so that downstream logic can suppress output energy on empty crossings.

Top module: `bx_tick_counter`

## Requirements
- R1: A synchronous active-high reset sets the counter to the preset reset value 11'h008 (tick 1, sub-tick 0), the turn number to 0, the live flag to 0 and the preset register to 11'h008.
- R2: Without a load, the counter value {tick_num, sub_tick} rises by one at every clock edge. sub_tick is counter bits [2:0] and tick_num is bits [10:3], so sub-tick 7 is followed by sub-tick 0 of the next tick.
- R3: From 11'h4FF (tick 159, sub-tick 7) the next edge gives 11'h008 (tick 1, sub-tick 0), and the turn number rises by one.
- R4: The turn number counts modulo 4 (0, 1, 2, 3, 0) and changes only at a rollover.
- R5: At an edge where first_edge and bot_mark are both high, the counter takes the preset register value and the turn number is unchanged. This load wins over a rollover at the same edge.
- R6: bot_mark has no effect at edges where first_edge is low.
- R7: live_flag takes the value of live_mark at edges where first_edge is high. At all other edges it holds its value.
- R8: At an edge where preset_we is high, the preset register takes preset_wdata. A load at that same edge still uses the previous preset value.
- R9: A counter value above 11'h4FF (a tick above 159, reachable through the preset) is followed by 11'h008 at the next edge, with the turn number rising by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at eight times the crossing rate |
| rst | input | 1 | Synchronous reset, active high |
| first_edge | input | 1 | Enable that is high at the edge starting a crossing |
| bot_mark | input | 1 | Begin-of-turn marker |
| live_mark | input | 1 | Live-crossing marker |
| preset_we | input | 1 | Preset write enable |
| preset_wdata | input | 11 | Preset value to write: {tick, sub-tick} |
| tick_num | output | 8 | Crossing tick number |
| sub_tick | output | 3 | Sub-tick number |
| turn_num | output | 2 | Partial turn number |
| live_flag | output | 1 | Live marker sampled at the latest crossing edge |

## Verification
Two pairs of events can fall on the same edge.

- **Load and rollover.** The bench first brings the counter to 11'h4FF. It then raises first_edge and bot_mark at the edge that would otherwise roll over. The outputs must show the preset value with the turn number unchanged, not 11'h008 with the turn advanced.
- **Preset write and load.** The bench writes a new preset in the same cycle as a load. The counter must show the old preset, and a later load must show the new one.

Each case is judged against a bench model built from the requirements, one edge at a time.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  localparam int BXC_TICK_W     = 8;
  localparam int BXC_SUB_W      = 3;
  localparam int BXC_TURN_W     = 2;
  localparam int BXC_FIRST_TICK = 1;
  localparam int BXC_LAST_TICK  = 159;

  typedef enum logic [1:0] {
    ACT_STEP = 2'd0,
    ACT_WRAP = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/bxc_preset_reg.sv
module bxc_preset_reg #(
  parameter int CNT_W = 11,
  parameter logic [CNT_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] preset
);
  always_ff @(posedge clk) begin
    if (rst)     preset <= INIT_VAL;
    else if (we) preset <= wdata;
  end

  // R8
  preset_wr_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> preset == $past(wdata));
endmodule

// File: rtl/bxc_marker_sampler.sv
module bxc_marker_sampler (
  input  logic clk,
  input  logic rst,
  input  logic first_edge,
  input  logic bot_mark,
  input  logic live_mark,
  output logic load_req,
  output logic live_q
);
  // The turn marker qualifies a load at the crossing edge itself
  assign load_req = first_edge & bot_mark;

  always_ff @(posedge clk) begin
    if (rst)             live_q <= 1'b0;
    else if (first_edge) live_q <= live_mark;
  end

  // R7
  live_take_chk: assert property (@(posedge clk) disable iff (rst)
    first_edge |=> live_q == $past(live_mark));
  // R7
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !first_edge |=> $stable(live_q));
endmodule

// File: rtl/bxc_counter.sv
module bxc_counter
  import bxc_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int SUB_W      = 3,
  parameter int TURN_W     = 2,
  parameter int FIRST_TICK = 1,
  parameter int LAST_TICK  = 159,
  parameter logic [TICK_W+SUB_W-1:0] INIT_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_req,
  input  logic [TICK_W+SUB_W-1:0] preset,
  output logic [TICK_W+SUB_W-1:0] cnt_q,
  output logic [TURN_W-1:0]       turn_q
);
  localparam int CNT_W = TICK_W + SUB_W;
  localparam logic [CNT_W-1:0] FIRST_VAL = {TICK_W'(FIRST_TICK), {SUB_W{1'b0}}};
  localparam logic [CNT_W-1:0] LAST_VAL  = {TICK_W'(LAST_TICK), {SUB_W{1'b1}}};

  cnt_act_e act;

  always_comb begin
    if (load_req)              act = ACT_LOAD;
    else if (cnt_q >= LAST_VAL) act = ACT_WRAP;
    else                       act = ACT_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= INIT_VAL;
      turn_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: cnt_q <= preset;
        ACT_WRAP: begin
          cnt_q  <= FIRST_VAL;
          turn_q <= turn_q + TURN_W'(1);
        end
        default:  cnt_q <= cnt_q + CNT_W'(1);
      endcase
    end
  end

  // R1
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == INIT_VAL && turn_q == '0));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_req && cnt_q < LAST_VAL) |=> (cnt_q == $past(cnt_q) + CNT_W'(1) && $stable(turn_q)));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_req && cnt_q >= LAST_VAL) |=> (cnt_q == FIRST_VAL && turn_q == $past(turn_q) + TURN_W'(1)));
  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (cnt_q == $past(preset) && $stable(turn_q)));
endmodule

// File: rtl/bx_tick_counter.sv
module bx_tick_counter
  import bxc_pkg::*;
#(
  parameter int TICK_W     = BXC_TICK_W,
  parameter int SUB_W      = BXC_SUB_W,
  parameter int TURN_W     = BXC_TURN_W,
  parameter int FIRST_TICK = BXC_FIRST_TICK,
  parameter int LAST_TICK  = BXC_LAST_TICK
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    first_edge,
  input  logic                    bot_mark,
  input  logic                    live_mark,
  input  logic                    preset_we,
  input  logic [TICK_W+SUB_W-1:0] preset_wdata,
  output logic [TICK_W-1:0]       tick_num,
  output logic [SUB_W-1:0]        sub_tick,
  output logic [TURN_W-1:0]       turn_num,
  output logic                    live_flag
);
  localparam int CNT_W = TICK_W + SUB_W;
  localparam logic [CNT_W-1:0] NOMINAL_PRESET = {TICK_W'(FIRST_TICK), {SUB_W{1'b0}}};

  logic [CNT_W-1:0] preset;
  logic [CNT_W-1:0] cnt_q;
  logic             load_req;

  bxc_preset_reg #(.CNT_W(CNT_W), .INIT_VAL(NOMINAL_PRESET)) i_preset (
    .clk(clk), .rst(rst), .we(preset_we), .wdata(preset_wdata), .preset(preset)
  );

  bxc_marker_sampler i_sampler (
    .clk(clk), .rst(rst), .first_edge(first_edge), .bot_mark(bot_mark),
    .live_mark(live_mark), .load_req(load_req), .live_q(live_flag)
  );

  bxc_counter #(
    .TICK_W(TICK_W), .SUB_W(SUB_W), .TURN_W(TURN_W),
    .FIRST_TICK(FIRST_TICK), .LAST_TICK(LAST_TICK), .INIT_VAL(NOMINAL_PRESET)
  ) i_counter (
    .clk(clk), .rst(rst), .load_req(load_req), .preset(preset),
    .cnt_q(cnt_q), .turn_q(turn_num)
  );

  assign sub_tick = cnt_q[SUB_W-1:0];
  assign tick_num = cnt_q[CNT_W-1:SUB_W];

  // R6
  bot_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!first_edge && cnt_q < {TICK_W'(LAST_TICK), {SUB_W{1'b1}}})
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: tb/test_bx_tick_counter.sv
module test_bx_tick_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        first_edge = 1'b0, bot_mark = 1'b0, live_mark = 1'b0, preset_we = 1'b0;
  logic [10:0] preset_wdata = '0;
  logic [7:0]  tick_num;
  logic [2:0]  sub_tick;
  logic [1:0]  turn_num;
  logic        live_flag;

  int n_cmp = 0, n_bad = 0;
  logic [10:0] ecnt, epre;
  logic [1:0]  eturn;
  logic        elive;

  always #5 clk = ~clk;

  bx_tick_counter i_bx_tick_counter (
    .clk(clk), .rst(rst), .first_edge(first_edge), .bot_mark(bot_mark),
    .live_mark(live_mark), .preset_we(preset_we), .preset_wdata(preset_wdata),
    .tick_num(tick_num), .sub_tick(sub_tick), .turn_num(turn_num), .live_flag(live_flag)
  );

  task automatic check_all(input string req);
    n_cmp++;
    if ({tick_num, sub_tick} !== ecnt || turn_num !== eturn || live_flag !== elive) begin
      n_bad++;
      $display("FAIL %s: got cnt=%h turn=%0d live=%b, expected cnt=%h turn=%0d live=%b",
               req, {tick_num, sub_tick}, turn_num, live_flag, ecnt, eturn, elive);
    end
  endtask

  // One clock edge with the given inputs; the model follows the requirements
  task automatic cyc(input logic fe, input logic bot, input logic lv,
                     input logic we, input logic [10:0] wd, input string req);
    first_edge = fe; bot_mark = bot; live_mark = lv; preset_we = we; preset_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (fe && bot) ecnt = epre;
    else if (ecnt >= 11'h4FF) begin ecnt = 11'h008; eturn = eturn + 2'd1; end
    else ecnt = ecnt + 11'd1;
    if (we) epre = wd;
    if (fe) elive = lv;
    first_edge = 1'b0; bot_mark = 1'b0; preset_we = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ecnt = 11'h008; epre = 11'h008; eturn = 2'd0; elive = 1'b0;
    check_all("R1 reset state");
  endtask

  task automatic t_count();
    for (int k = 0; k < 13; k++) cyc(0, 0, 0, 0, '0, "R2 increment");
  endtask

  task automatic t_ignore_bot();
    for (int k = 0; k < 5; k++) cyc(0, 1, 1, 0, '0, "R6 bot ignored off crossing edge");
  endtask

  task automatic t_live();
    cyc(1, 0, 1, 0, '0, "R7 live sampled high");
    for (int k = 0; k < 7; k++) cyc(0, 0, k[0], 0, '0, "R7 live held");
    cyc(1, 0, 0, 0, '0, "R7 live sampled low");
  endtask

  task automatic t_rollover();
    cyc(0, 0, 0, 1, 11'h4FC, "R8 preset write");
    cyc(1, 1, 0, 0, '0, "R5 load preset");
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, '0, "R3 rollover");
  endtask

  task automatic t_turn_wrap();
    cyc(0, 0, 0, 1, 11'h4FF, "R8 preset write");
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 0, 0, '0, "R5 load keeps turn");
      cyc(0, 0, 0, 0, '0, "R4 turn modulo 4");
    end
  endtask

  task automatic t_coincide();
    cyc(0, 0, 0, 1, 11'h4FE, "R8 preset write");
    cyc(1, 1, 0, 1, 11'h123, "R8 load uses old preset");
    cyc(0, 0, 0, 0, '0, "R2 step to 4FF");
    cyc(1, 1, 0, 0, '0, "R5 load beats rollover");
    cyc(0, 0, 0, 0, '0, "R2 step after load");
  endtask

  task automatic t_out_of_range();
    cyc(0, 0, 0, 1, 11'h7F8, "R8 preset write");
    cyc(1, 1, 0, 0, '0, "R5 load tick 255");
    cyc(0, 0, 0, 0, '0, "R9 wrap from out-of-range tick");
    cyc(0, 0, 0, 0, '0, "R2 step after wrap");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_ignore_bot();
    t_live();
    t_rollover();
    t_turn_wrap();
    t_coincide();
    t_out_of_range();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule